// File: doc/BRIEF.md
# Three-Wire Serial Command Frame Receiver

This block sits at the front of a multi-channel DAC controller. It takes 16-bit command words from a three-wire serial link made of a serial clock, a data line and a frame strobe. All three wires are brought into the faster system clock domain and their edges are found there. The block recognises a frame, shifts the bits in and presents each accepted word on a parallel bus. A one-cycle strobe marks every accepted word. It also drives a cascade output so that several receivers can share one serial link.

The block has two framing disciplines, selected by a static input. In the host-controller discipline the strobe frames the whole word, and the word is committed when the strobe rises. In the signal-processor discipline the strobe only marks the start of a frame. That frame needs a serial clock falling edge before it can start, and once started it always runs for 16 bits. Decoding the word and storing it are done by the register stage that follows.

Top module: `sdac_frame_rx`

## Requirements
- R1: A frame starts on a falling edge of `fs_in`. Data is taken MSB first, one bit on each falling edge of `sclk_in`, and appears on `word_o` with bit 15 holding the first bit received.
- R2: When 16 bits have been collected, the word appears on `word_o`. `word_o` changes only in a cycle where `word_valid_o` is high.
- R3: With `mode_mcu`=1, a rise of `fs_in` before the 16th falling `sclk_in` edge discards the transfer. No strobe is produced and `word_o` keeps its previous value.
- R4: With `mode_mcu`=1, a complete word is committed only on the next rise of `fs_in`. No strobe appears while `fs_in` stays low after the 16th bit.
- R5: With `mode_mcu`=0, `fs_in` may rise at any point after a frame has started, and the frame still collects all 16 bits.
- R6: With `mode_mcu`=0, a new frame starts only if `sclk_in` had a falling edge while `fs_in` was high since the last falling edge of `fs_in`. Otherwise the falling edge of `fs_in` is ignored and no word is produced.
- R7: With `chain_en`=1, `dout_o` after the k-th falling `sclk_in` edge since reset equals the `din_in` bit taken at edge k-16, or 0 when k<16. With `chain_en`=0, `dout_o` is 0.
- R8: After reset, `word_o` is all zeros and `word_valid_o` and `dout_o` are low.
- R9: `word_valid_o` is high for exactly one system clock for each accepted frame, and never for a discarded or ignored frame.
- R10: A falling edge of `fs_in` while a frame is in progress restarts the frame, so the next 16 bits form the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_mcu | input | 1 | 1 = host-controller framing, 0 = signal-processor framing |
| chain_en | input | 1 | Enables the cascade output |
| sclk_in | input | 1 | Serial clock, asynchronous to `clk` |
| din_in | input | 1 | Serial data |
| fs_in | input | 1 | Frame strobe, active low |
| word_o | output | 16 | Last accepted word |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |
| dout_o | output | 1 | Serial data delayed by 16 serial clocks |

## Verification
The checks assume that each phase of the serial clock lasts at least two system clocks, so two falling edges are never seen in consecutive cycles. They also assume that data and the frame strobe never change near a falling serial clock edge, and that the framing mode stays fixed while a frame is open. The stimulus holds each serial clock phase for five system clocks. It changes data and the strobe only while the serial clock is high, with a full phase of margin before the next falling edge, and it switches mode only between frames.

// File: rtl/sdac_rx_pkg.sv
package sdac_rx_pkg;

    typedef enum logic {
        FRM_DSP = 1'b0,
        FRM_MCU = 1'b1
    } frm_mode_e;

    typedef struct packed {
        logic sclk_fall;
        logic fs_fall;
        logic fs_rise;
        logic fs_lvl;
        logic din;
    } ser_evt_t;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync
    import sdac_rx_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk_i,
    input  logic     fs_i,
    input  logic     din_i,
    output ser_evt_t evt_o
);

    localparam int unsigned NSIG = 3;

    typedef struct packed {
        logic [STAGES-1:0][NSIG-1:0] pipe;
        logic [NSIG-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;
    logic [NSIG-1:0] cur, prv;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[STAGES-2:0], {fs_i, sclk_i, din_i}};
        s_d.prev = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur = s_q.pipe[STAGES-1];
    assign prv = s_q.prev;

    always_comb begin
        evt_o.sclk_fall = prv[1] & ~cur[1];
        evt_o.fs_fall   = prv[2] & ~cur[2];
        evt_o.fs_rise   = ~prv[2] & cur[2];
        evt_o.fs_lvl    = cur[2];
        evt_o.din       = cur[0];
    end

    // R1
    sclk_oversample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.sclk_fall |=> !evt_o.sclk_fall);

endmodule

// File: rtl/sdac_framer.sv
module sdac_framer
    import sdac_rx_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  frm_mode_e mode_i,
    input  ser_evt_t  evt_i,
    output logic [W-1:0] word_o,
    output logic         valid_o
);

    localparam int unsigned CW = $clog2(W + 1);

    typedef struct packed {
        logic          active;
        logic          armed;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  shreg;
        logic [W-1:0]  word;
        logic          valid;
    } frm_t;

    frm_t f_d, f_q;
    logic [W-1:0] shifted;

    assign shifted = {f_q.shreg[W-2:0], evt_i.din};

    always_comb begin
        f_d       = f_q;
        f_d.valid = 1'b0;
        if (evt_i.sclk_fall && evt_i.fs_lvl) f_d.armed = 1'b1;
        if (evt_i.fs_fall) begin
            if (mode_i == FRM_MCU || f_q.armed || f_q.active) begin
                f_d.active = 1'b1;
                f_d.cnt    = '0;
                f_d.done   = 1'b0;
            end
            f_d.armed = 1'b0;
        end else if (mode_i == FRM_MCU && evt_i.fs_rise) begin
            if (f_q.done) begin
                f_d.word  = f_q.shreg;
                f_d.valid = 1'b1;
            end
            f_d.active = 1'b0;
            f_d.done   = 1'b0;
        end else if (f_q.active && evt_i.sclk_fall) begin
            f_d.shreg = shifted;
            f_d.cnt   = f_q.cnt + CW'(1);
            if (f_q.cnt == CW'(W - 1)) begin
                f_d.active = 1'b0;
                if (mode_i == FRM_MCU) begin
                    f_d.done = 1'b1;
                end else begin
                    f_d.word  = shifted;
                    f_d.valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign word_o  = f_q.word;
    assign valid_o = f_q.valid;

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.valid |=> !f_q.valid);

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.word != $past(f_q.word)) |-> f_q.valid);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(W));

    // R4
    mcu_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.valid && $past(mode_i == FRM_MCU)) |-> $past(evt_i.fs_rise));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.fs_fall && mode_i == FRM_MCU) |=> (f_q.cnt == '0 && f_q.active));

endmodule

// File: rtl/sdac_chain.sv
module sdac_chain #(
    parameter int unsigned DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sclk_fall_i,
    input  logic din_i,
    output logic dout_o
);

    typedef struct packed {
        logic [DEPTH-1:0] dly;
        logic             out;
    } chain_t;

    chain_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (sclk_fall_i) begin
            c_d.out = c_q.dly[DEPTH-1];
            c_d.dly = {c_q.dly[DEPTH-2:0], din_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign dout_o = en_i & c_q.out;

    // R7
    dout_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.out != $past(c_q.out)) |-> $past(sclk_fall_i));

endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
    import sdac_rx_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CHAIN_DEPTH = FRAME_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_mcu,
    input  logic                  chain_en,
    input  logic                  sclk_in,
    input  logic                  din_in,
    input  logic                  fs_in,
    output logic [FRAME_BITS-1:0] word_o,
    output logic                  word_valid_o,
    output logic                  dout_o
);

    ser_evt_t  evt;
    frm_mode_e mode;

    assign mode = frm_mode_e'(mode_mcu);

    sdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_in),
        .fs_i   (fs_in),
        .din_i  (din_in),
        .evt_o  (evt)
    );

    sdac_framer #(.W(FRAME_BITS)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .evt_i   (evt),
        .word_o  (word_o),
        .valid_o (word_valid_o)
    );

    sdac_chain #(.DEPTH(CHAIN_DEPTH)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (chain_en),
        .sclk_fall_i (evt.sclk_fall),
        .din_i       (evt.din),
        .dout_o      (dout_o)
    );

endmodule

// File: tb/tb_sdac_frame_rx.sv
module tb_sdac_frame_rx;

    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_mcu = 1'b1;
    logic        chain_en = 1'b0;
    logic        sclk_in = 1'b1;
    logic        din_in = 1'b0;
    logic        fs_in = 1'b1;
    logic [15:0] word_o;
    logic        word_valid_o;
    logic        dout_o;

    always #10 clk = ~clk;

    sdac_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .mode_mcu(mode_mcu), .chain_en(chain_en),
        .sclk_in(sclk_in), .din_in(din_in), .fs_in(fs_in),
        .word_o(word_o), .word_valid_o(word_valid_o), .dout_o(dout_o)
    );

    int nchk = 0;
    int nfail = 0;
    int pulses = 0;
    int edge_n = 0;
    bit chk_chain = 0;
    bit hist [0:4095];
    logic [15:0] exp_q[$];
    string       req_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [15:0] w, input string req);
        exp_q.push_back(w);
        req_q.push_back(req);
    endtask

    // Monitor: pops expected words as strobes appear
    always @(negedge clk) begin
        if (rst_n && word_valid_o) begin
            pulses++;
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected strobe", {16'h0, word_o}, 0);
            end else begin
                logic [15:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(word_o == e, r, "word", {16'h0, word_o}, {16'h0, e});
            end
        end
    end

    task automatic fall_edge();
        logic expb;
        sclk_in = 1'b0;
        hist[edge_n] = din_in;
        tick(HALF);
        if (chk_chain) begin
            expb = (chain_en && edge_n >= 16) ? hist[edge_n-16] : 1'b0;
            chk(dout_o == expb, "R7", "dout", {31'h0, dout_o}, {31'h0, expb});
        end
        edge_n++;
        sclk_in = 1'b1;
        tick(HALF);
    endtask

    task automatic send_bits(input logic [15:0] w, input int n, input int rise_at);
        for (int i = 0; i < n; i++) begin
            din_in = w[15-i];
            tick(HALF);
            fall_edge();
            if (i == rise_at) fs_in = 1'b1;
        end
    endtask

    task automatic frame(input logic [15:0] w, input int n, input bit pre, input int rise_at);
        if (pre) begin
            din_in = 1'b0;
            tick(HALF);
            fall_edge();
        end
        fs_in = 1'b0;
        tick(HALF);
        send_bits(w, n, rise_at);
        tick(HALF);
        fs_in = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", "run timed out", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int p0;
        logic [15:0] w0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R8 reset state
        chk(word_o == 16'h0, "R8", "word after reset", {16'h0, word_o}, 0);
        chk(word_valid_o == 1'b0, "R8", "strobe after reset", {31'h0, word_valid_o}, 0);
        chk(dout_o == 1'b0, "R8", "dout after reset", {31'h0, dout_o}, 0);

        // R1 R2 host-controller framing, several patterns
        mode_mcu = 1'b1;
        push(16'hA5C3, "R1"); frame(16'hA5C3, 16, 0, -1);
        push(16'hFFFF, "R2"); frame(16'hFFFF, 16, 0, -1);
        push(16'h8001, "R1"); frame(16'h8001, 16, 0, -1);

        // R3 short frame discarded
        p0 = pulses; w0 = word_o;
        frame(16'h1234, 10, 0, -1);
        chk(pulses == p0, "R3", "strobe count after cancel", pulses, p0);
        chk(word_o == w0, "R3", "word after cancel", {16'h0, word_o}, {16'h0, w0});

        // R4 commit waits for strobe rise
        p0 = pulses;
        fs_in = 1'b0; tick(HALF);
        send_bits(16'h3C5A, 16, -1);
        tick(6 * HALF);
        chk(pulses == p0, "R4", "strobe before fs rise", pulses, p0);
        push(16'h3C5A, "R4");
        fs_in = 1'b1; tick(4 * HALF);
        chk(pulses == p0 + 1, "R4", "strobe after fs rise", pulses, p0 + 1);

        // R6 signal-processor framing with no preceding clock edge
        mode_mcu = 1'b0;
        p0 = pulses; w0 = word_o;
        frame(16'h0F0F, 16, 0, -1);
        chk(pulses == p0, "R6", "strobe without lead edge", pulses, p0);
        chk(word_o == w0, "R6", "word without lead edge", {16'h0, word_o}, {16'h0, w0});

        // R5 early strobe rise in signal-processor framing
        push(16'h6E91, "R5"); frame(16'h6E91, 16, 1, 2);
        push(16'h0002, "R5"); frame(16'h0002, 16, 1, 0);

        // R10 restart mid-frame
        p0 = pulses;
        din_in = 1'b0; tick(HALF); fall_edge();
        fs_in = 1'b0; tick(HALF);
        send_bits(16'hFFFF, 5, -1);
        fs_in = 1'b1; tick(2 * HALF);
        fs_in = 1'b0; tick(HALF);
        push(16'hC0DE, "R10");
        send_bits(16'hC0DE, 16, -1);
        tick(HALF); fs_in = 1'b1; tick(4 * HALF);
        chk(pulses == p0 + 1, "R10", "one strobe after restart", pulses, p0 + 1);

        // R7 cascade output, enabled then disabled
        chain_en = 1'b1; chk_chain = 1;
        push(16'hB28D, "R7"); frame(16'hB28D, 16, 1, -1);
        push(16'h4A71, "R7"); frame(16'h4A71, 16, 1, -1);
        chain_en = 1'b0;
        push(16'hFFFF, "R7"); frame(16'hFFFF, 16, 1, -1);
        chk_chain = 0;

        tick(10);
        // R9 every expected strobe seen, none left
        chk(exp_q.size() == 0, "R9", "missing strobes", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule